// File: doc/BRIEF.md
# Single-Word Peripheral-to-Memory Transfer Engine

This block copies one data word from a peripheral register into a memory location on the shared system bus, so the processor never has to run a service routine for it. Software first loads a source address and a destination address through a small configuration write port. When the peripheral raises its service request, the engine asks the processor for the system bus. Once the processor grants it, the engine acknowledges the peripheral, performs one bus read at the source address and one bus write at the destination address, and then hands the bus back.

Two four-phase handshakes run in an interlocked order. The bus-ownership pair (`bus_req` to the processor, `bus_grant` back) wraps the service pair (`per_req` from the peripheral, `per_ack` back). Both outgoing lines drop in the same cycle once the write has been issued. The engine returns to idle only after the processor has withdrawn its grant and the peripheral has withdrawn its request. The bus is modelled as an output-enable bus: whenever the engine does not own it, every driven bus output is zero and `bus_oe` is low.

The controller has seven states. ST_IDLE goes to ST_ASK_BUS when a request arrives. ST_ASK_BUS holds until the grant is seen and then goes to ST_READ, which is the read strobe. ST_CAPTURE latches the read data and is followed by ST_WRITE, the write strobe. ST_FINISH carries the completion pulse. From there the machine goes to ST_IDLE if grant and request are both low, and otherwise to ST_WAIT_DROP, where it stays until both are low.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, `bus_req`, `per_ack`, `bus_oe`, `bus_en`, `xfer_done` and `xfer_status` are all 0.
- R2: A `cfg_we` cycle in ST_IDLE loads `cfg_wdata` into the source address (`cfg_sel`=0) or the destination address (`cfg_sel`=1). A `cfg_we` cycle in any other state has no effect on the transfer.
- R3: A `per_req` seen high in ST_IDLE raises `bus_req` in the next cycle. `per_ack` stays low until `bus_grant` has been seen high.
- R4: `bus_oe` and `bus_en` are high only while `bus_grant` is high. When `bus_oe` is low, `bus_en`, `bus_wr`, `bus_addr` and `bus_wdata` are all 0.
- R5: In the cycle after `bus_grant` is first sampled high, the engine issues a one-cycle read strobe (`bus_en`=1, `bus_wr`=0, `bus_addr`=source) and `per_ack` is high.
- R6: `bus_rdata` is sampled in the cycle after the read strobe. The cycle after that carries a one-cycle write strobe (`bus_en`=1, `bus_wr`=1, `bus_addr`=destination, `bus_wdata`=the sampled word).
- R7: `bus_req` and `per_ack` fall together in the cycle after the write strobe.
- R8: `xfer_done` is a one-cycle pulse in that same cycle. `xfer_status` rises in the same cycle and stays high until the next request is accepted, when it clears.
- R9: After a transfer, no new `bus_req` is raised until `bus_grant` and `per_req` have both been seen low. A `per_req` that stays high in the meantime is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects source address, 1 selects destination address |
| cfg_wdata | input | ADDR_W | Configuration write data |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Service acknowledge to the peripheral |
| bus_req | output | 1 | Bus ownership request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| bus_oe | output | 1 | High while the engine drives the bus |
| bus_en | output | 1 | Bus access strobe |
| bus_wr | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid the cycle after a read strobe |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_status | output | 1 | Completed-transfer flag |

## Verification
The bench builds the engine with ADDR_W=16 and DATA_W=12. The 12-bit word width is not a byte multiple, so a truncated or misaligned data path shows up in the scoreboard. The 16-bit address width allows source and destination addresses far apart, such as 0x8000 and 0x0001. The bench also varies three things: how long the processor delays its grant, how long it holds the grant after release, and how long the peripheral keeps its request up. This exercises the wait in ST_ASK_BUS, the ST_WAIT_DROP path and the direct ST_FINISH-to-idle path. The bench also issues a configuration write in the middle of a transfer to check that it is ignored.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ASK_BUS   = 3'd1,
        ST_READ      = 3'd2,
        ST_CAPTURE   = 3'd3,
        ST_WRITE     = 3'd4,
        ST_FINISH    = 3'd5,
        ST_WAIT_DROP = 3'd6
    } dma_state_e;

    localparam logic CFG_SEL_SRC = 1'b0;
    localparam logic CFG_SEL_DST = 1'b1;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    import dma_xfer_pkg::*;

    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (wr_en) begin
            if (sel == CFG_SEL_SRC) src_q <= wdata;
            else                    dst_q <= wdata;
        end
    end

    assign src_addr = src_q;
    assign dst_addr = dst_q;

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic per_req,
    input  logic bus_grant,
    output logic idle,
    output logic own_bus,
    output logic rd_strobe,
    output logic cap_en,
    output logic wr_strobe,
    output logic bus_req,
    output logic per_ack,
    output logic done,
    output logic status
);
    import dma_xfer_pkg::*;

    dma_state_e state_q;
    dma_state_e state_d;
    logic       status_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (per_req)   state_d = ST_ASK_BUS;
            ST_ASK_BUS:   if (bus_grant) state_d = ST_READ;
            ST_READ:                     state_d = ST_CAPTURE;
            ST_CAPTURE:                  state_d = ST_WRITE;
            ST_WRITE:                    state_d = ST_FINISH;
            ST_FINISH:
                if (!bus_grant && !per_req) state_d = ST_IDLE;
                else                        state_d = ST_WAIT_DROP;
            ST_WAIT_DROP:
                if (!bus_grant && !per_req) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Completion flag: set on finish, cleared when a new request is taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              status_q <= 1'b0;
        else if (state_q == ST_WRITE)            status_q <= 1'b1;
        else if (state_q == ST_IDLE && per_req)  status_q <= 1'b0;
    end

    // Moore outputs
    always_comb begin
        idle      = 1'b0;
        own_bus   = 1'b0;
        rd_strobe = 1'b0;
        cap_en    = 1'b0;
        wr_strobe = 1'b0;
        bus_req   = 1'b0;
        per_ack   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:      idle = 1'b1;
            ST_ASK_BUS:   bus_req = 1'b1;
            ST_READ: begin
                bus_req   = 1'b1;
                per_ack   = 1'b1;
                own_bus   = 1'b1;
                rd_strobe = 1'b1;
            end
            ST_CAPTURE: begin
                bus_req = 1'b1;
                per_ack = 1'b1;
                own_bus = 1'b1;
                cap_en  = 1'b1;
            end
            ST_WRITE: begin
                bus_req   = 1'b1;
                per_ack   = 1'b1;
                own_bus   = 1'b1;
                wr_strobe = 1'b1;
            end
            ST_FINISH:    done = 1'b1;
            ST_WAIT_DROP: ;
            default:      ;
        endcase
    end

    assign status = status_q;

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_bus,
    input  logic              rd_strobe,
    input  logic              cap_en,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_oe,
    output logic              bus_en,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= '0;
        else if (cap_en) hold_q <= bus_rdata;
    end

    always_comb begin
        bus_oe    = own_bus;
        bus_en    = own_bus & (rd_strobe | wr_strobe);
        bus_wr    = own_bus & wr_strobe;
        bus_addr  = '0;
        bus_wdata = '0;
        if (own_bus && rd_strobe) bus_addr = src_addr;
        if (own_bus && wr_strobe) begin
            bus_addr  = dst_addr;
            bus_wdata = hold_q;
        end
    end

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              per_req,
    output logic              per_ack,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              bus_oe,
    output logic              bus_en,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              xfer_done,
    output logic              xfer_status
);
    logic              idle;
    logic              own_bus;
    logic              rd_strobe;
    logic              cap_en;
    logic              wr_strobe;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;

    dma_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_req   (per_req),
        .bus_grant (bus_grant),
        .idle      (idle),
        .own_bus   (own_bus),
        .rd_strobe (rd_strobe),
        .cap_en    (cap_en),
        .wr_strobe (wr_strobe),
        .bus_req   (bus_req),
        .per_ack   (per_ack),
        .done      (xfer_done),
        .status    (xfer_status)
    );

    dma_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we & idle),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    dma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_bus   (own_bus),
        .rd_strobe (rd_strobe),
        .cap_en    (cap_en),
        .wr_strobe (wr_strobe),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .bus_rdata (bus_rdata),
        .bus_oe    (bus_oe),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
module dma_xfer_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              per_req,
    input logic              per_ack,
    input logic              bus_req,
    input logic              bus_grant,
    input logic              bus_oe,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              xfer_done,
    input logic              xfer_status
);
    // R4
    grant_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> bus_grant);

    // R4
    quiet_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (!bus_en && !bus_wr && bus_addr == '0 && bus_wdata == '0));

    // R3
    ack_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> (bus_grant && bus_req));

    // R5
    strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |=> !bus_en);

    // R7
    joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $fell(per_ack));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R8
    done_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (xfer_status && !bus_req && !per_ack));

    // R9
    no_early_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !$past(bus_grant));

endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .per_req     (per_req),
    .per_ack     (per_ack),
    .bus_req     (bus_req),
    .bus_grant   (bus_grant),
    .bus_oe      (bus_oe),
    .bus_en      (bus_en),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .xfer_done   (xfer_done),
    .xfer_status (xfer_status)
);

// File: tb/dma_xfer_ctrl_bench.sv
module dma_xfer_ctrl_bench;
    localparam int AW = 16;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          per_req = 1'b0;
    logic          per_ack;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic          bus_oe;
    logic          bus_en;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          xfer_done;
    logic          xfer_status;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    logic [AW-1:0] cur_src = '0;
    logic [DW-1:0] periph_val = '0;
    logic [AW+DW-1:0] exp_q[$];

    always #10 clk = ~clk;

    dma_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dma_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .per_req(per_req), .per_ack(per_ack),
        .bus_req(bus_req), .bus_grant(bus_grant), .bus_oe(bus_oe),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xfer_done(xfer_done), .xfer_status(xfer_status)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Peripheral read model: wrong address corrupts the word
    always @(posedge clk) begin
        if (bus_oe && bus_en && !bus_wr)
            bus_rdata <= periph_val ^ DW'(bus_addr ^ cur_src);
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_oe && !bus_grant)
                check(1'b0, "R4", "bus driven without grant", 32'(bus_oe), 32'd0);
            if (!bus_oe)
                if (bus_en || bus_wr || bus_addr != '0 || bus_wdata != '0)
                    check(1'b0, "R4", "bus lines active while released",
                          32'(bus_addr), 32'd0);
            if (bus_oe && bus_en && bus_wr) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected write", 32'(bus_addr), 32'd0);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    check(bus_addr == e[AW+DW-1:DW], "R6", "write address",
                          32'(bus_addr), 32'(e[AW+DW-1:DW]));
                    check(bus_wdata == e[DW-1:0], "R6", "write data",
                          32'(bus_wdata), 32'(e[DW-1:0]));
                end
            end
        end
    end

    task automatic cfg_write(input logic sel, input logic [AW-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One full transfer. Inputs change on negedges, outputs sampled on negedges.
    task automatic run_xfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                            input logic [DW-1:0] data, input int grant_dly,
                            input int grant_hold, input int req_hold,
                            input bit poke_cfg, input bit load_cfg);
        if (load_cfg) begin
            cfg_write(1'b0, src);   // R2 source
            cfg_write(1'b1, dst);   // R2 destination
        end
        cur_src = src;
        periph_val = data;
        exp_q.push_back({dst, data});
        @(negedge clk);
        per_req = 1'b1;
        @(negedge clk);
        check(bus_req == 1'b1, "R3", "bus_req after per_req", 32'(bus_req), 32'd1);
        check(per_ack == 1'b0, "R3", "ack before grant", 32'(per_ack), 32'd0);
        check(xfer_status == 1'b0, "R8", "status cleared on accept", 32'(xfer_status), 32'd0);
        if (poke_cfg) begin
            cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = ~dst;   // R2 ignored when busy
            @(negedge clk);
            cfg_we = 1'b0;
        end
        for (int i = 0; i < grant_dly; i++) begin
            check(per_ack == 1'b0 && bus_oe == 1'b0, "R3", "idle bus while waiting",
                  32'({per_ack, bus_oe}), 32'd0);
            @(negedge clk);
        end
        bus_grant = 1'b1;
        @(negedge clk);   // ST_READ
        check(per_ack == 1'b1, "R5", "ack with read", 32'(per_ack), 32'd1);
        check(bus_en && !bus_wr && bus_addr == src, "R5", "read strobe address",
              32'(bus_addr), 32'(src));
        @(negedge clk);   // ST_CAPTURE
        check(bus_en == 1'b0, "R6", "no strobe in capture", 32'(bus_en), 32'd0);
        @(negedge clk);   // ST_WRITE, checked by monitor
        check(bus_req == 1'b1 && per_ack == 1'b1, "R7", "held through write",
              32'({bus_req, per_ack}), 32'd3);
        @(negedge clk);   // ST_FINISH
        check(bus_req == 1'b0 && per_ack == 1'b0, "R7", "joint release",
              32'({bus_req, per_ack}), 32'd0);
        check(xfer_done == 1'b1 && xfer_status == 1'b1, "R8", "done and status",
              32'({xfer_done, xfer_status}), 32'd3);
        for (int i = 0; (i < grant_hold) || (i < req_hold); i++) begin
            if (i >= grant_hold) bus_grant = 1'b0;
            if (i >= req_hold)   per_req = 1'b0;
            @(negedge clk);
            check(bus_req == 1'b0, "R9", "no restart before both drop", 32'(bus_req), 32'd0);
            check(xfer_done == 1'b0, "R8", "done single cycle", 32'(xfer_done), 32'd0);
        end
        bus_grant = 1'b0;
        per_req = 1'b0;
        repeat (2) @(negedge clk);
        check(bus_req == 1'b0 && xfer_status == 1'b1, "R8", "status holds in idle",
              32'({bus_req, xfer_status}), 32'd1);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            check(exp_q.size() == 0, "R6", "all expected writes seen", 32'(exp_q.size()), 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bus_req == 0 && per_ack == 0, "R1", "handshake low in reset",
              32'({bus_req, per_ack}), 32'd0);
        check(bus_oe == 0 && bus_en == 0, "R1", "bus released in reset",
              32'({bus_oe, bus_en}), 32'd0);
        check(xfer_done == 0 && xfer_status == 0, "R1", "flags low in reset",
              32'({xfer_done, xfer_status}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_req == 0 && xfer_status == 0, "R1", "idle after reset",
              32'({bus_req, xfer_status}), 32'd0);

        run_xfer(16'h8000, 16'h0001, 12'hA5C, 0, 0, 0, 1'b0, 1'b1);
        run_xfer(16'h8000, 16'h0001, 12'h3F1, 3, 2, 0, 1'b0, 1'b0);
        run_xfer(16'h4002, 16'hFFFE, 12'hFFF, 2, 0, 4, 1'b1, 1'b1);
        run_xfer(16'h0010, 16'h7000, 12'h000, 1, 5, 3, 1'b1, 1'b1);
        run_xfer(16'hFFFF, 16'h0000, 12'h801, 6, 1, 1, 1'b0, 1'b1);
        finish_run();
    end

endmodule